// File: doc/BRIEF.md
# Boot Memory Remap Selector

This block steers every bus address that falls in the low alias window at zero to a physical memory that software picks. It also routes accesses in the flash main window to one of two equal flash banks. A 3-bit mode value selects the memory that answers in the alias window. One swap bit exchanges the two flash halves, and the exchange applies in the main window and in the alias window alike. The mode is loaded from boot strap inputs when reset ends. Software can overwrite it afterwards through a small write/read port.

For each request address the block gives a target code, the address translated into that target's own space and a decode-error flag. The decode uses only combinational logic and sees the configuration registers as they currently stand. The flash size is a parameter. The flash base sits on a boundary that is a multiple of the flash size, so the in-bank offset is simply the low address bits.

A dual-bank boot input forces system memory into the alias window while it is asserted. The stored mode does not change while the input forces the alias.

Top module: `boot_remap_unit`

## Requirements
- R1: The stored mode takes the value of `strap_mode` on the third rising clock edge after `rst_n` deasserts, and the swap bit starts at 0. Readback `cfg_rdata` = {swap, mode[2:0]}.
- R2: A write with `cfg_we` high stores `cfg_wdata[2:0]` as the mode and `cfg_wdata[3]` as the swap bit on that clock edge. Without a write the readback holds its value.
- R3: A write that arrives on the same edge as the strap capture takes priority, and the strap value is discarded.
- R4: In the main window [FLASH_BASE, FLASH_BASE+FLASH_BYTES), the bank is (offset >= FLASH_BYTES/2) XOR swap: target code 1 means bank 1, 2 means bank 2. The translated address is the offset modulo FLASH_BYTES/2.
- R5: Mode 000 maps the alias window onto flash with the same bank and swap rule. Alias addresses at or above FLASH_BYTES raise the decode error.
- R6: Mode 001 gives target 3 (system memory) with the address passed through. Addresses at or above SYS_BYTES raise the decode error.
- R7: Mode 010 gives target 4 (external memory) only within its first two regions (< 2*EXT_REGION_BYTES). Any address above that raises the decode error.
- R8: Mode 011 gives target 5 (SRAM) below SRAM_BYTES. Any address at or above that raises the decode error.
- R9: Modes 100 and 101 give targets 6 and 7 (first and second octal-SPI memory) for the whole alias window, with the address passed through.
- R10: Modes 110 and 111 are reserved. Alias accesses under them raise the decode error with target 0 and translated address 0. Every decode error carries target 0.
- R11: While `dual_boot` is high, the alias window decodes as mode 001 whatever mode is stored.
- R12: An address outside both windows gives target 0, no error and the address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_mode | input | 3 | Boot strap mode, captured as reset ends |
| dual_boot | input | 1 | Forces system memory into the alias window |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | {swap, mode} write value |
| cfg_rdata | output | 4 | {swap, mode} readback |
| req_addr | input | 32 | Request address |
| tgt_sel | output | 3 | Target code |
| tgt_addr | output | 32 | Address within the target |
| decode_err | output | 1 | Alias access with no legal target |

## Verification
Two functions can act on the same clock edge: the strap capture and a software write. The bench sets this up by counting edges from the reset release and asserting `cfg_we` for exactly the capture edge. It then requires the readback to show the written value rather than the strap. A second overlap is forced under random stimulus: `dual_boot` high while a different mode is stored. Each decode result there is judged against a bench model that lets the force override the stored mode while leaving the readback unchanged.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_BANK1  = 3'd1,
    TGT_BANK2  = 3'd2,
    TGT_SYSMEM = 3'd3,
    TGT_EXTMEM = 3'd4,
    TGT_SRAM   = 3'd5,
    TGT_OSPI1  = 3'd6,
    TGT_OSPI2  = 3'd7
  } tgt_e;

  localparam int unsigned MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_FLASH  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_SYSMEM = 3'd1;
  localparam logic [MODE_W-1:0] MODE_EXTMEM = 3'd2;
  localparam logic [MODE_W-1:0] MODE_SRAM   = 3'd3;
  localparam logic [MODE_W-1:0] MODE_OSPI1  = 3'd4;
  localparam logic [MODE_W-1:0] MODE_OSPI2  = 3'd5;
endpackage

// File: rtl/remap_rst_sync.sv
module remap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/remap_cfg_reg.sv
module remap_cfg_reg
  import remap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] strap_mode,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              wr_swap,
  output logic [MODE_W-1:0] mode_q,
  output logic              swap_q
);
  logic              capture_q;
  logic [MODE_W-1:0] mode_d;
  logic              swap_d;
  logic              upd_en;

  // software write outranks the one-shot strap capture
  always_comb begin
    mode_d = mode_q;
    swap_d = swap_q;
    upd_en = wr_en | capture_q;
    if (wr_en) begin
      mode_d = wr_mode;
      swap_d = wr_swap;
    end else if (capture_q) begin
      mode_d = strap_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capture_q <= 1'b1;
      mode_q    <= '0;
      swap_q    <= 1'b0;
    end else begin
      capture_q <= 1'b0;
      if (upd_en) begin
        mode_q <= mode_d;
        swap_q <= swap_d;
      end
    end
  end
endmodule

// File: rtl/remap_bank_xlate.sv
module remap_bank_xlate #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned HALF_W = 20
) (
  input  logic [HALF_W:0]   offset,
  input  logic              swap,
  output logic              hi_bank,
  output logic [ADDR_W-1:0] local_addr
);
  always_comb begin
    hi_bank    = offset[HALF_W] ^ swap;
    local_addr = '0;
    local_addr[HALF_W-1:0] = offset[HALF_W-1:0];
  end
endmodule

// File: rtl/remap_alias_dec.sv
module remap_alias_dec
  import remap_pkg::*;
#(
  parameter int unsigned ADDR_W          = 32,
  parameter int unsigned FLASH_BYTES     = 32'h0020_0000,
  parameter int unsigned SYS_BYTES       = 32'h0001_0000,
  parameter int unsigned SRAM_BYTES      = 32'h0003_0000,
  parameter int unsigned EXT_REGION_BYTES = 32'h0200_0000
) (
  input  logic [MODE_W-1:0] eff_mode,
  input  logic [ADDR_W-1:0] addr,
  output logic              flash_hit,
  output logic [2:0]        sel,
  output logic [ADDR_W-1:0] out_addr,
  output logic              err
);
  localparam logic [ADDR_W-1:0] FLASH_LIM = ADDR_W'(FLASH_BYTES);
  localparam logic [ADDR_W-1:0] SYS_LIM   = ADDR_W'(SYS_BYTES);
  localparam logic [ADDR_W-1:0] SRAM_LIM  = ADDR_W'(SRAM_BYTES);
  localparam logic [ADDR_W-1:0] EXT_LIM   = ADDR_W'(2 * EXT_REGION_BYTES);

  logic       in_lim;
  logic [2:0] cand;

  always_comb begin
    flash_hit = 1'b0;
    in_lim    = 1'b0;
    cand      = TGT_NONE;
    case (eff_mode)
      MODE_FLASH:  begin in_lim = addr < FLASH_LIM; flash_hit = in_lim; end
      MODE_SYSMEM: begin in_lim = addr < SYS_LIM;  cand = TGT_SYSMEM; end
      MODE_EXTMEM: begin in_lim = addr < EXT_LIM;  cand = TGT_EXTMEM; end
      MODE_SRAM:   begin in_lim = addr < SRAM_LIM; cand = TGT_SRAM;   end
      MODE_OSPI1:  begin in_lim = 1'b1;            cand = TGT_OSPI1;  end
      MODE_OSPI2:  begin in_lim = 1'b1;            cand = TGT_OSPI2;  end
      default:     begin in_lim = 1'b0;            cand = TGT_NONE;   end
    endcase
    err      = ~in_lim;
    sel      = in_lim ? cand : TGT_NONE;
    out_addr = (in_lim && !flash_hit) ? addr : '0;
  end
endmodule

// File: rtl/boot_remap_unit.sv
module boot_remap_unit
  import remap_pkg::*;
#(
  parameter int unsigned ADDR_W           = 32,
  parameter int unsigned FLASH_BASE       = 32'h0800_0000,
  parameter int unsigned FLASH_BYTES      = 32'h0020_0000,
  parameter int unsigned ALIAS_BYTES      = 32'h0800_0000,
  parameter int unsigned SYS_BYTES        = 32'h0001_0000,
  parameter int unsigned SRAM_BYTES       = 32'h0003_0000,
  parameter int unsigned EXT_REGION_BYTES = 32'h0200_0000,
  parameter int unsigned SYNC_STAGES      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        strap_mode,
  input  logic              dual_boot,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_wdata,
  output logic [3:0]        cfg_rdata,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [2:0]        tgt_sel,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              decode_err
);
  localparam int unsigned       HALF_W     = $clog2(FLASH_BYTES / 2);
  localparam logic [ADDR_W-1:0] MAIN_LO    = ADDR_W'(FLASH_BASE);
  localparam logic [ADDR_W-1:0] MAIN_HI    = ADDR_W'(FLASH_BASE + FLASH_BYTES);
  localparam logic [ADDR_W-1:0] ALIAS_LIM  = ADDR_W'(ALIAS_BYTES);

  logic              rst_sync_n;
  logic [MODE_W-1:0] mode_q;
  logic              swap_q;
  logic [MODE_W-1:0] eff_mode;
  logic              in_main;
  logic              in_alias;
  logic              al_flash_hit;
  logic [2:0]        al_sel;
  logic [ADDR_W-1:0] al_addr;
  logic              al_err;
  logic              hi_bank;
  logic [ADDR_W-1:0] bank_addr;

  remap_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  remap_cfg_reg cfg_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .strap_mode (strap_mode),
    .wr_en      (cfg_we),
    .wr_mode    (cfg_wdata[2:0]),
    .wr_swap    (cfg_wdata[3]),
    .mode_q     (mode_q),
    .swap_q     (swap_q)
  );

  assign cfg_rdata = {swap_q, mode_q};
  assign eff_mode  = dual_boot ? MODE_SYSMEM : mode_q;
  assign in_main   = (req_addr >= MAIN_LO) && (req_addr < MAIN_HI);
  assign in_alias  = req_addr < ALIAS_LIM;

  remap_alias_dec #(
    .ADDR_W           (ADDR_W),
    .FLASH_BYTES      (FLASH_BYTES),
    .SYS_BYTES        (SYS_BYTES),
    .SRAM_BYTES       (SRAM_BYTES),
    .EXT_REGION_BYTES (EXT_REGION_BYTES)
  ) alias_i (
    .eff_mode  (eff_mode),
    .addr      (req_addr),
    .flash_hit (al_flash_hit),
    .sel       (al_sel),
    .out_addr  (al_addr),
    .err       (al_err)
  );

  // base is aligned to the flash size, so low bits are the offset in both windows
  remap_bank_xlate #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) bank_i (
    .offset     (req_addr[HALF_W:0]),
    .swap       (swap_q),
    .hi_bank    (hi_bank),
    .local_addr (bank_addr)
  );

  always_comb begin
    tgt_sel    = TGT_NONE;
    tgt_addr   = req_addr;
    decode_err = 1'b0;
    if (in_main || (in_alias && al_flash_hit)) begin
      tgt_sel  = hi_bank ? TGT_BANK2 : TGT_BANK1;
      tgt_addr = bank_addr;
    end else if (in_alias) begin
      tgt_sel    = al_sel;
      tgt_addr   = al_addr;
      decode_err = al_err;
    end
  end
endmodule

// File: rtl/boot_remap_unit_chk.sv
module boot_remap_unit_chk #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned FLASH_BASE  = 32'h0800_0000,
  parameter int unsigned FLASH_BYTES = 32'h0020_0000,
  parameter int unsigned ALIAS_BYTES = 32'h0800_0000,
  parameter int unsigned SYS_BYTES   = 32'h0001_0000
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              dual_boot,
  input logic              cfg_we,
  input logic [3:0]        cfg_wdata,
  input logic [3:0]        cfg_rdata,
  input logic [ADDR_W-1:0] req_addr,
  input logic [2:0]        tgt_sel,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic              decode_err
);
  localparam logic [ADDR_W-1:0] LO   = ADDR_W'(FLASH_BASE);
  localparam logic [ADDR_W-1:0] HI   = ADDR_W'(FLASH_BASE + FLASH_BYTES);
  localparam logic [ADDR_W-1:0] HALF = ADDR_W'(FLASH_BYTES / 2);
  localparam logic [ADDR_W-1:0] AL   = ADDR_W'(ALIAS_BYTES);
  localparam logic [ADDR_W-1:0] SYSL = ADDR_W'(SYS_BYTES);

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_we && $past(rst_sync_n)) |=> $stable(cfg_rdata));

  a_r4_bank_local: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tgt_sel == 3'd1 || tgt_sel == 3'd2) |-> (tgt_addr < HALF && !decode_err));

  a_r10_err_no_target: assert property (@(posedge clk) disable iff (!rst_sync_n)
    decode_err |-> (tgt_sel == 3'd0 && req_addr < AL));

  a_r11_dual_sys: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dual_boot && req_addr < SYSL) |-> (tgt_sel == 3'd3 && !decode_err));

  a_r12_outside: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_addr >= AL && !(req_addr >= LO && req_addr < HI))
      |-> (tgt_sel == 3'd0 && !decode_err && tgt_addr == req_addr));
endmodule

bind boot_remap_unit boot_remap_unit_chk #(
  .ADDR_W      (ADDR_W),
  .FLASH_BASE  (FLASH_BASE),
  .FLASH_BYTES (FLASH_BYTES),
  .ALIAS_BYTES (ALIAS_BYTES),
  .SYS_BYTES   (SYS_BYTES)
) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .dual_boot  (dual_boot),
  .cfg_we     (cfg_we),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .req_addr   (req_addr),
  .tgt_sel    (tgt_sel),
  .tgt_addr   (tgt_addr),
  .decode_err (decode_err)
);

// File: tb/boot_remap_unit_tb_top.sv
`timescale 1ns/1ps
module boot_remap_unit_tb_top;
  localparam logic [31:0] FB    = 32'h0800_0000;
  localparam logic [31:0] FBY   = 32'h0020_0000;
  localparam logic [31:0] HALF  = 32'h0010_0000;
  localparam logic [31:0] ALIAS = 32'h0800_0000;
  localparam logic [31:0] SYSB  = 32'h0001_0000;
  localparam logic [31:0] SRAMB = 32'h0003_0000;
  localparam logic [31:0] EXTL  = 32'h0400_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  strap_mode;
  logic        dual_boot;
  logic        cfg_we;
  logic [3:0]  cfg_wdata;
  logic [3:0]  cfg_rdata;
  logic [31:0] req_addr;
  logic [2:0]  tgt_sel;
  logic [31:0] tgt_addr;
  logic        decode_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [2:0] m_mode;
  logic       m_swap;

  always #4 clk = ~clk;

  boot_remap_unit dut_i (
    .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode), .dual_boot(dual_boot),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_addr(req_addr), .tgt_sel(tgt_sel), .tgt_addr(tgt_addr),
    .decode_err(decode_err)
  );

  function automatic logic [35:0] flash_res(logic [31:0] off, logic sw);
    logic hi;
    hi = (off >= HALF) ^ sw;
    return {1'b0, hi ? 3'd2 : 3'd1, off % HALF};
  endfunction

  function automatic logic [35:0] model(logic [2:0] md, logic sw, logic dual, logic [31:0] a);
    logic [2:0]  m;
    logic [35:0] bad;
    bad = {1'b1, 3'd0, 32'd0};
    if (a >= FB && a < FB + FBY) return flash_res(a - FB, sw);
    if (a >= ALIAS) return {1'b0, 3'd0, a};
    m = dual ? 3'd1 : md;
    case (m)
      3'd0: return (a < FBY)   ? flash_res(a, sw) : bad;
      3'd1: return (a < SYSB)  ? {1'b0, 3'd3, a} : bad;
      3'd2: return (a < EXTL)  ? {1'b0, 3'd4, a} : bad;
      3'd3: return (a < SRAMB) ? {1'b0, 3'd5, a} : bad;
      3'd4: return {1'b0, 3'd6, a};
      3'd5: return {1'b0, 3'd7, a};
      default: return bad;
    endcase
  endfunction

  function automatic string req_tag(logic [2:0] md, logic dual, logic [31:0] a);
    if (a >= FB && a < FB + FBY) return "R4";
    if (a >= ALIAS) return "R12";
    if (dual) return "R11";
    case (md)
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R8";
      3'd4, 3'd5: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check_dec();
    logic [35:0] exp_v, got;
    string tag;
    exp_v = model(m_mode, m_swap, dual_boot, req_addr);
    tag   = req_tag(m_mode, dual_boot, req_addr);
    got   = {decode_err, tgt_sel, tgt_addr};
    checks++;
    if (got !== exp_v) begin
      errors++;
      $display("FAIL %s addr=%h mode=%0d swap=%0d dual=%0d got err=%0d sel=%0d addr=%h exp err=%0d sel=%0d addr=%h",
               tag, req_addr, m_mode, m_swap, dual_boot, got[35], got[34:32], got[31:0],
               exp_v[35], exp_v[34:32], exp_v[31:0]);
    end
  endtask

  task automatic check_rd(input string tag);
    checks++;
    if (cfg_rdata !== {m_swap, m_mode}) begin
      errors++;
      $display("FAIL %s readback got=%h exp=%h", tag, cfg_rdata, {m_swap, m_mode});
    end
  endtask

  task automatic probe(input logic [31:0] a, input logic dual);
    @(negedge clk);
    req_addr  = a;
    dual_boot = dual;
    #1;
    check_dec();
  endtask

  task automatic wr(input logic [2:0] md, input logic sw);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = {sw, md};
    @(negedge clk);
    cfg_we = 1'b0;
    m_mode = md;
    m_swap = sw;
  endtask

  task automatic do_reset(input logic [2:0] strap);
    rst_n      = 1'b0;
    strap_mode = strap;
    cfg_we     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_mode = strap;
    m_swap = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; strap_mode = 3'd0; dual_boot = 1'b0;
    cfg_we = 1'b0; cfg_wdata = 4'd0; req_addr = 32'd0;
    m_mode = 3'd0; m_swap = 1'b0;

    // R1: strap captured, swap cleared
    do_reset(3'b011);
    check_rd("R1");
    probe(32'h0000_0100, 1'b0);
    do_reset(3'b101);
    check_rd("R1");

    // R3: write on the capture edge beats the strap
    rst_n = 1'b0; strap_mode = 3'b001;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 4'b1100;
    @(negedge clk);
    cfg_we = 1'b0;
    m_mode = 3'd4; m_swap = 1'b1;
    check_rd("R3");

    // R2 / R4: bank boundaries for both swap values
    for (int s = 0; s < 2; s++) begin
      wr(3'd0, s[0]);
      check_rd("R2");
      probe(FB, 1'b0);
      probe(FB + HALF - 1, 1'b0);
      probe(FB + HALF, 1'b0);
      probe(FB + FBY - 1, 1'b0);
      probe(FB + FBY, 1'b0);        // R12
      probe(FB - 1, 1'b0);          // R5 alias past flash
      probe(HALF, 1'b0);            // R5 alias bank 2 half
      probe(FBY - 1, 1'b0);
    end
    wr(3'd1, 1'b0); probe(SYSB - 1, 1'b0); probe(SYSB, 1'b0);            // R6
    wr(3'd2, 1'b0); probe(EXTL - 1, 1'b0); probe(EXTL, 1'b0);            // R7
    wr(3'd3, 1'b1); probe(SRAMB - 1, 1'b0); probe(SRAMB, 1'b0);          // R8
    probe(32'h0000_0040, 1'b1);                                          // R11
    check_rd("R11");
    wr(3'd4, 1'b0); probe(ALIAS - 1, 1'b0);                              // R9
    wr(3'd5, 1'b0); probe(32'h0123_4560, 1'b0);
    wr(3'd6, 1'b0); probe(32'h0000_0000, 1'b0);                          // R10
    wr(3'd7, 1'b1); probe(32'h0000_1000, 1'b0); probe(FB + 32'h10, 1'b0);

    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] a;
      case ($urandom % 5)
        0: a = $urandom % 32'h0030_0000;
        1: a = $urandom % ALIAS;
        2: a = FB + ($urandom % FBY);
        3: a = $urandom;
        default: begin
          case ($urandom % 10)
            0: a = SYSB - 1;  1: a = SYSB;
            2: a = SRAMB - 1; 3: a = SRAMB;
            4: a = EXTL - 1;  5: a = EXTL;
            6: a = FBY - 1;   7: a = FBY;
            8: a = HALF - 1;  default: a = HALF;
          endcase
        end
      endcase
      probe(a, ($urandom % 8) == 0);
      check_rd("R2");
      if (($urandom % 6) == 0) wr(3'($urandom % 8), 1'($urandom % 2));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule